// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Write Inhibit

A clocked memory with two fully independent access ports, left and right. Each port has its own address, active-low chip enable, read/write select, active-low output enable, active-low upper and lower byte-lane selects, and an active-low select that steers the access to semaphore space. Both ports can read or write any word in the same cycle, and neither port ever waits on the other. Writes are masked per byte lane. A write is dropped without notice while that port's write-block input is high. That input is fed by an external busy arbiter.

Reads are registered. The data comes back one clock after the request, together with a two-bit per-lane valid flag. This flag replaces the tri-state outputs of an asynchronous part. A lane that is not valid reads as zero. Accesses that select semaphore space never touch the array. The semaphore flags and the arbiter that produces the write-block inputs sit outside this block.

The array holds 2^ADDR_W words of 2*LANE_W bits. With ADDR_W = 14 and LANE_W = 8 it is 16384 words of 16 bits. The default build is smaller.

Top module: `lane_dpram`

## Requirements
- R1: A port writes when chip enable is low, semaphore select is high and read/write is low (0 = write). Bits 15:8 are written only if the upper select is low. Bits 7:0 are written only if the lower select is low. A lane whose select is high keeps its old contents.
- R2: A read needs chip enable low, semaphore select high, read/write high and output enable low. One cycle later, rvalid bit 1 (upper) and bit 0 (lower) are set for each lane whose select was low, and those lanes carry the stored bytes. An unselected lane shows valid 0 and data 0.
- R3: With chip enable high the port is deselected. It writes nothing, and the next cycle shows rvalid 0 and rdata 0.
- R4: With semaphore select low the array is neither written nor read, and the next cycle shows rvalid 0.
- R5: While write-block is high, writes from that port are discarded. Reads on that port still return data.
- R6: The two ports operate independently. Concurrent accesses to any addresses complete, each with one cycle of read latency.
- R7: If both ports write the same word in the same cycle and neither is blocked, the right port's data wins in every lane it writes. A lane written only by the left port takes the left data.
- R8: A read of a word that the other port writes in the same cycle returns the contents from before that write.
- R9: A read request with output enable high yields rvalid 0 and rdata 0. A write cycle (read/write low) yields no read data on that port.
- R10: While reset is asserted, both ports show rvalid 0 and rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_addr_i | input | ADDR_W | Left word address |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_rw_i | input | 1 | Left read (1) / write (0) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_ub_ni | input | 1 | Left upper lane select, active low |
| l_lb_ni | input | 1 | Left lower lane select, active low |
| l_sem_ni | input | 1 | Left semaphore-space select, active low |
| l_wr_block_i | input | 1 | Left write block from arbiter |
| l_wdata_i | input | 2*LANE_W | Left write data |
| l_rdata_o | output | 2*LANE_W | Left read data, zero in invalid lanes |
| l_rvalid_o | output | 2 | Left lane valid, bit 1 upper |
| r_addr_i | input | ADDR_W | Right word address |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_rw_i | input | 1 | Right read (1) / write (0) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_ub_ni | input | 1 | Right upper lane select, active low |
| r_lb_ni | input | 1 | Right lower lane select, active low |
| r_sem_ni | input | 1 | Right semaphore-space select, active low |
| r_wr_block_i | input | 1 | Right write block from arbiter |
| r_wdata_i | input | 2*LANE_W | Right write data |
| r_rdata_o | output | 2*LANE_W | Right read data, zero in invalid lanes |
| r_rvalid_o | output | 2 | Right lane valid, bit 1 upper |

## Verification
The bench builds the block with ADDR_W = 6 and LANE_W = 8, which gives 64 words of 16 bits. A directed pass first fills every word. The random traffic then forces one port's address onto the other's in about a quarter of the cycles, so same-word write collisions and reads during writes happen hundreds of times, not almost never. The small depth also lets a bench-side shadow array cover every word, so each lane-masked, blocked or semaphore-steered write is later read back and compared.

// File: rtl/lane_dpram_pkg.sv
package lane_dpram_pkg;
  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;
  localparam int NUM_LANES = 2;
  localparam int LANE_LO   = 0;
  localparam int LANE_UP   = 1;

  typedef struct packed {
    logic ce_n;
    logic rw;
    logic oe_n;
    logic sem_n;
    logic blk;
  } port_ctl_t;

  function automatic logic array_sel(port_ctl_t c);
    return !c.ce_n && c.sem_n;
  endfunction
endpackage

// File: rtl/lane_dpram_dec.sv
module lane_dpram_dec
  import lane_dpram_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  port_ctl_t        ctl_i,
  input  logic [LANES-1:0] lane_sel_ni,
  output logic [LANES-1:0] wr_en_o,
  output logic [LANES-1:0] rd_en_o
);
  logic wr_cyc, rd_cyc;

  always_comb begin
    wr_cyc = array_sel(ctl_i) && !ctl_i.rw && !ctl_i.blk;
    rd_cyc = array_sel(ctl_i) && ctl_i.rw && !ctl_i.oe_n;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_en_o[g] = wr_cyc && !lane_sel_ni[g];
    assign rd_en_o[g] = rd_cyc && !lane_sel_ni[g];
  end
endmodule

// File: rtl/lane_dpram_bank.sv
module lane_dpram_bank #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic              a_re_i,
  input  logic [LANE_W-1:0] a_wdata_i,
  output logic [LANE_W-1:0] a_rdata_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  input  logic              b_re_i,
  input  logic [LANE_W-1:0] b_wdata_i,
  output logic [LANE_W-1:0] b_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // reads sample pre-write contents; port b write lands last
  always_ff @(posedge clk_i) begin
    if (a_re_i) a_rdata_o <= mem[a_addr_i];
    if (b_re_i) b_rdata_o <= mem[b_addr_i];
    if (a_we_i) mem[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem[b_addr_i] <= b_wdata_i;
  end
endmodule

// File: rtl/lane_dpram_rdout.sv
module lane_dpram_rdout #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             rd_en_i,
  input  logic [LANES-1:0][LANE_W-1:0] lane_q_i,
  output logic [LANES-1:0]             rvalid_o,
  output logic [LANES*LANE_W-1:0]      rdata_o
);
  logic [LANES-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= rd_en_i;
  end

  assign rvalid_o = valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign rdata_o[g*LANE_W +: LANE_W] = valid_q[g] ? lane_q_i[g] : '0;
  end
endmodule

// File: rtl/lane_dpram.sv
module lane_dpram
  import lane_dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     l_addr_i,
  input  logic                  l_ce_ni,
  input  logic                  l_rw_i,
  input  logic                  l_oe_ni,
  input  logic                  l_ub_ni,
  input  logic                  l_lb_ni,
  input  logic                  l_sem_ni,
  input  logic                  l_wr_block_i,
  input  logic [2*LANE_W-1:0]   l_wdata_i,
  output logic [2*LANE_W-1:0]   l_rdata_o,
  output logic [1:0]            l_rvalid_o,
  input  logic [ADDR_W-1:0]     r_addr_i,
  input  logic                  r_ce_ni,
  input  logic                  r_rw_i,
  input  logic                  r_oe_ni,
  input  logic                  r_ub_ni,
  input  logic                  r_lb_ni,
  input  logic                  r_sem_ni,
  input  logic                  r_wr_block_i,
  input  logic [2*LANE_W-1:0]   r_wdata_i,
  output logic [2*LANE_W-1:0]   r_rdata_o,
  output logic [1:0]            r_rvalid_o
);
  localparam int DATA_W = NUM_LANES * LANE_W;

  port_ctl_t [NUM_PORTS-1:0]                        ctl;
  logic      [NUM_PORTS-1:0][NUM_LANES-1:0]         lane_sel_n;
  logic      [NUM_PORTS-1:0][ADDR_W-1:0]            addr;
  logic      [NUM_PORTS-1:0][DATA_W-1:0]            wdata;
  logic      [NUM_PORTS-1:0][NUM_LANES-1:0]         wr_en;
  logic      [NUM_PORTS-1:0][NUM_LANES-1:0]         rd_en;
  logic      [NUM_PORTS-1:0][NUM_LANES-1:0][LANE_W-1:0] lane_q;
  logic      [NUM_PORTS-1:0][NUM_LANES-1:0]         rvalid;
  logic      [NUM_PORTS-1:0][DATA_W-1:0]            rdata;

  assign ctl[PORT_L] = '{ce_n: l_ce_ni, rw: l_rw_i, oe_n: l_oe_ni,
                         sem_n: l_sem_ni, blk: l_wr_block_i};
  assign ctl[PORT_R] = '{ce_n: r_ce_ni, rw: r_rw_i, oe_n: r_oe_ni,
                         sem_n: r_sem_ni, blk: r_wr_block_i};
  assign lane_sel_n[PORT_L] = {l_ub_ni, l_lb_ni};
  assign lane_sel_n[PORT_R] = {r_ub_ni, r_lb_ni};
  assign addr[PORT_L]  = l_addr_i;
  assign addr[PORT_R]  = r_addr_i;
  assign wdata[PORT_L] = l_wdata_i;
  assign wdata[PORT_R] = r_wdata_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    lane_dpram_dec #(.LANES(NUM_LANES)) u_dec (
      .ctl_i       (ctl[p]),
      .lane_sel_ni (lane_sel_n[p]),
      .wr_en_o     (wr_en[p]),
      .rd_en_o     (rd_en[p])
    );

    lane_dpram_rdout #(.LANES(NUM_LANES), .LANE_W(LANE_W)) u_rdout (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_en_i  (rd_en[p]),
      .lane_q_i (lane_q[p]),
      .rvalid_o (rvalid[p]),
      .rdata_o  (rdata[p])
    );
  end

  // right port on the b side so it wins same-word collisions
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_bank
    lane_dpram_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk_i     (clk_i),
      .a_addr_i  (addr[PORT_L]),
      .a_we_i    (wr_en[PORT_L][g]),
      .a_re_i    (rd_en[PORT_L][g]),
      .a_wdata_i (wdata[PORT_L][g*LANE_W +: LANE_W]),
      .a_rdata_o (lane_q[PORT_L][g]),
      .b_addr_i  (addr[PORT_R]),
      .b_we_i    (wr_en[PORT_R][g]),
      .b_re_i    (rd_en[PORT_R][g]),
      .b_wdata_i (wdata[PORT_R][g*LANE_W +: LANE_W]),
      .b_rdata_o (lane_q[PORT_R][g])
    );
  end

  assign l_rdata_o  = rdata[PORT_L];
  assign l_rvalid_o = rvalid[PORT_L];
  assign r_rdata_o  = rdata[PORT_R];
  assign r_rvalid_o = rvalid[PORT_R];
endmodule

// File: rtl/lane_dpram_chk.sv
module lane_dpram_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                l_ce_ni,
  input logic                l_rw_i,
  input logic                l_oe_ni,
  input logic                l_ub_ni,
  input logic                l_lb_ni,
  input logic                l_sem_ni,
  input logic [2*LANE_W-1:0] l_rdata_o,
  input logic [1:0]          l_rvalid_o,
  input logic                r_ce_ni,
  input logic                r_rw_i,
  input logic                r_oe_ni,
  input logic                r_ub_ni,
  input logic                r_lb_ni,
  input logic                r_sem_ni,
  input logic [2*LANE_W-1:0] r_rdata_o,
  input logic [1:0]          r_rvalid_o
);
  p_read_lanes_r2_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_ni && l_sem_ni && l_rw_i && !l_oe_ni) |=> (l_rvalid_o == ~$past({l_ub_ni, l_lb_ni})));
  p_read_lanes_r2_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_ce_ni && r_sem_ni && r_rw_i && !r_oe_ni) |=> (r_rvalid_o == ~$past({r_ub_ni, r_lb_ni})));

  p_quiet_lane_r2_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!l_rvalid_o[1] -> l_rdata_o[2*LANE_W-1:LANE_W] == '0) &&
     (!l_rvalid_o[0] -> l_rdata_o[LANE_W-1:0] == '0)));
  p_quiet_lane_r2_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!r_rvalid_o[1] -> r_rdata_o[2*LANE_W-1:LANE_W] == '0) &&
     (!r_rvalid_o[0] -> r_rdata_o[LANE_W-1:0] == '0)));

  p_deselect_r3_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_ce_ni |=> (l_rvalid_o == 2'b00));
  p_deselect_r3_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_ce_ni |=> (r_rvalid_o == 2'b00));

  p_sem_space_r4_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_sem_ni |=> (l_rvalid_o == 2'b00));
  p_sem_space_r4_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_sem_ni |=> (r_rvalid_o == 2'b00));

  p_no_read_r9_l: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_rw_i || l_oe_ni) |=> (l_rvalid_o == 2'b00));
  p_no_read_r9_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_rw_i || r_oe_ni) |=> (r_rvalid_o == 2'b00));
endmodule

bind lane_dpram lane_dpram_chk #(.LANE_W(LANE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .l_ce_ni    (l_ce_ni),
  .l_rw_i     (l_rw_i),
  .l_oe_ni    (l_oe_ni),
  .l_ub_ni    (l_ub_ni),
  .l_lb_ni    (l_lb_ni),
  .l_sem_ni   (l_sem_ni),
  .l_rdata_o  (l_rdata_o),
  .l_rvalid_o (l_rvalid_o),
  .r_ce_ni    (r_ce_ni),
  .r_rw_i     (r_rw_i),
  .r_oe_ni    (r_oe_ni),
  .r_ub_ni    (r_ub_ni),
  .r_lb_ni    (r_lb_ni),
  .r_sem_ni   (r_sem_ni),
  .r_rdata_o  (r_rdata_o),
  .r_rvalid_o (r_rvalid_o)
);

// File: tb/lane_dpram_test.sv
module lane_dpram_test;
  localparam int AW    = 6;
  localparam int LW    = 8;
  localparam int DW    = 2 * LW;
  localparam int WORDS = 1 << AW;

  typedef struct packed {
    logic [AW-1:0] a;
    logic ce_n, rw, oe_n, ub_n, lb_n, sem_n, blk;
    logic [DW-1:0] wd;
  } pctl_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  pctl_t lp, rp;
  logic [DW-1:0] l_rd, r_rd;
  logic [1:0]    l_rv, r_rv;
  logic [DW-1:0] model [WORDS];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  lane_dpram #(.ADDR_W(AW), .LANE_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_addr_i(lp.a), .l_ce_ni(lp.ce_n), .l_rw_i(lp.rw), .l_oe_ni(lp.oe_n),
    .l_ub_ni(lp.ub_n), .l_lb_ni(lp.lb_n), .l_sem_ni(lp.sem_n),
    .l_wr_block_i(lp.blk), .l_wdata_i(lp.wd), .l_rdata_o(l_rd), .l_rvalid_o(l_rv),
    .r_addr_i(rp.a), .r_ce_ni(rp.ce_n), .r_rw_i(rp.rw), .r_oe_ni(rp.oe_n),
    .r_ub_ni(rp.ub_n), .r_lb_ni(rp.lb_n), .r_sem_ni(rp.sem_n),
    .r_wr_block_i(rp.blk), .r_wdata_i(rp.wd), .r_rdata_o(r_rd), .r_rvalid_o(r_rv)
  );

  function automatic pctl_t idle();
    pctl_t p;
    p = '0;
    p.ce_n = 1'b1; p.rw = 1'b1; p.oe_n = 1'b1;
    p.ub_n = 1'b1; p.lb_n = 1'b1; p.sem_n = 1'b1;
    return p;
  endfunction

  function automatic pctl_t wr(logic [AW-1:0] a, logic [DW-1:0] d, logic ub_n, logic lb_n);
    pctl_t p;
    p = idle();
    p.a = a; p.ce_n = 1'b0; p.rw = 1'b0; p.ub_n = ub_n; p.lb_n = lb_n; p.wd = d;
    return p;
  endfunction

  function automatic pctl_t rd(logic [AW-1:0] a);
    pctl_t p;
    p = idle();
    p.a = a; p.ce_n = 1'b0; p.oe_n = 1'b0; p.ub_n = 1'b0; p.lb_n = 1'b0;
    return p;
  endfunction

  function automatic pctl_t rnd();
    pctl_t p;
    p.a     = AW'($urandom);
    p.ce_n  = ($urandom % 5) == 0;
    p.rw    = ($urandom % 2) == 0;
    p.oe_n  = ($urandom % 6) == 0;
    p.ub_n  = ($urandom % 4) == 0;
    p.lb_n  = ($urandom % 4) == 0;
    p.sem_n = ($urandom % 8) != 0;
    p.blk   = ($urandom % 5) == 0;
    p.wd    = DW'($urandom);
    return p;
  endfunction

  // expected {valid_up, valid_lo, data} from the requirements
  function automatic logic [DW+1:0] expect_rd(pctl_t p);
    logic ok, vu, vl;
    logic [DW-1:0] w;
    ok = !p.ce_n && p.sem_n && p.rw && !p.oe_n;
    vu = ok && !p.ub_n;
    vl = ok && !p.lb_n;
    w  = model[p.a];
    return {vu, vl, (vu ? w[DW-1:LW] : {LW{1'b0}}), (vl ? w[LW-1:0] : {LW{1'b0}})};
  endfunction

  task automatic apply_wr(pctl_t p);
    if (!p.ce_n && p.sem_n && !p.rw && !p.blk) begin
      if (!p.ub_n) model[p.a][DW-1:LW] = p.wd[DW-1:LW];
      if (!p.lb_n) model[p.a][LW-1:0]  = p.wd[LW-1:0];
    end
  endtask

  task automatic check(string tag, string side, logic [DW+1:0] got, logic [DW+1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s port: got %h expected %h", tag, side, got, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic [DW+1:0] el, er;
    el = expect_rd(lp);
    er = expect_rd(rp);
    apply_wr(lp);   // left first, right overwrites (R7)
    apply_wr(rp);
    @(posedge clk);
    #1;
    check(tag, "left", {l_rv, l_rd}, el);
    check(tag, "right", {r_rv, r_rd}, er);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    lp = rd('0);
    rp = rd('0);
    repeat (3) @(posedge clk);
    #1;
    check("R10", "left", {l_rv, l_rd}, '0);
    check("R10", "right", {r_rv, r_rd}, '0);
    rst_n = 1'b1;

    // fill every word, both ports concurrently (R6)
    for (int a = 0; a < WORDS; a += 2) begin
      lp = wr(AW'(a), DW'($urandom), 1'b0, 1'b0);
      rp = wr(AW'(a + 1), DW'($urandom), 1'b0, 1'b0);
      cyc("R6");
    end
    lp = rd(AW'(3)); rp = rd(AW'(4)); cyc("R6");

    // R1: single-lane writes
    lp = wr(AW'(5), 16'hABCD, 1'b0, 1'b1); rp = idle(); cyc("R1");
    lp = rd(AW'(5)); cyc("R1");
    rp = wr(AW'(6), 16'h1357, 1'b1, 1'b0); lp = idle(); cyc("R1");
    rp = rd(AW'(6)); cyc("R1");

    // R2: partial lane read and both lanes deselected
    lp = rd(AW'(5)); lp.lb_n = 1'b1; rp = rd(AW'(6)); rp.ub_n = 1'b1; cyc("R2");
    lp = rd(AW'(5)); lp.lb_n = 1'b1; lp.ub_n = 1'b1; rp = idle(); cyc("R2");

    // R5: blocked write dropped, blocked read still served
    lp = wr(AW'(7), 16'hDEAD, 1'b0, 1'b0); lp.blk = 1'b1; cyc("R5");
    lp = rd(AW'(7)); lp.blk = 1'b1; cyc("R5");

    // R7: same-word collision
    lp = wr(AW'(9), 16'h1111, 1'b0, 1'b0); rp = wr(AW'(9), 16'h2222, 1'b0, 1'b1); cyc("R7");
    lp = rd(AW'(9)); rp = idle(); cyc("R7");
    lp = wr(AW'(9), 16'h3333, 1'b0, 1'b0); rp = wr(AW'(9), 16'h4444, 1'b0, 1'b0); cyc("R7");
    lp = idle(); rp = rd(AW'(9)); cyc("R7");

    // R8: read during other port's write returns old word
    lp = wr(AW'(10), 16'h5A5A, 1'b0, 1'b0); rp = rd(AW'(10)); cyc("R8");
    lp = rd(AW'(10)); rp = wr(AW'(10), 16'hA5A5, 1'b0, 1'b0); cyc("R8");
    lp = rd(AW'(10)); rp = idle(); cyc("R8");

    // R4: semaphore-space accesses skip the array
    lp = wr(AW'(11), 16'hFFFF, 1'b0, 1'b0); lp.sem_n = 1'b0; cyc("R4");
    lp = rd(AW'(11)); lp.sem_n = 1'b0; rp = rd(AW'(11)); cyc("R4");

    // R3: deselected write ignored
    lp = wr(AW'(12), 16'h0F0F, 1'b0, 1'b0); lp.ce_n = 1'b1; rp = idle(); cyc("R3");
    lp = rd(AW'(12)); cyc("R3");

    // R9: output enable high, and write cycles, give no read data
    lp = rd(AW'(12)); lp.oe_n = 1'b1; rp = wr(AW'(13), 16'h7777, 1'b0, 1'b0); rp.oe_n = 1'b0; cyc("R9");
    lp = idle(); rp = rd(AW'(13)); cyc("R9");

    // random traffic with forced address collisions (R6)
    for (int i = 0; i < 4000; i++) begin
      lp = rnd();
      rp = rnd();
      if (($urandom % 4) == 0) rp.a = lp.a;
      cyc("R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule